// File: doc/BRIEF.md
# Grouped Machine Timer with Aliased Time Counter

This block holds one 64-bit time counter that serves a group of harts. Each hart has its own register window. The window holds a private 64-bit compare register and a read-only view of the shared counter. A further window belongs to no hart and has no compare register. It carries the only writable view of the counter, so it is the one place where software can set the group's time.

The counter advances by one on each cycle in which `tick_en` is high. Each hart gets one level-sensitive timer interrupt. That interrupt is high whenever the shared counter, compared as an unsigned 64-bit number, has reached the hart's compare value. Compare values are absolute times, not delays. A write to the counter or to a compare register can therefore raise an interrupt or drop it.

Registers are reached over a plain single-cycle register bus: address, write strobe, 32-bit write data and per-byte enables. Read data is combinational from the address. Hart `i` owns the 16-byte window at `i*0x10`. The hart-less window sits directly above the last hart.

Top module: `grouped_timer`

## Requirements
- R1: The time words read back identically from every window. These are offsets 0x8 (low) and 0xC (high) of each hart window, and offsets 0x0 (low) and 0x4 (high) of the hart-less window at `NUM_HARTS*0x10`. All of them show the single shared counter.
- R2: A write to offset 0x8 or 0xC of a hart window changes nothing. The shared counter keeps its value.
- R3: A write to offset 0x0 or 0x4 of the hart-less window replaces those bytes of the counter whose byte enable (bit b selects data bits 8b+7..8b) is set. The other half and the unselected bytes keep their values.
- R4: With no counter write in a cycle, `tick_en` high adds one to the counter at the clock edge. The count wraps from all ones to zero.
- R5: A counter write in a cycle with `tick_en` high takes effect as in R3, and that cycle does not increment the counter.
- R6: Each hart has its own compare register at offsets 0x0 (low) and 0x4 (high) of its window, written per byte as in R3. Writing one hart's compare leaves every other hart's compare unchanged.
- R7: `irq[i]` is high exactly when counter >= compare of hart i, taken as unsigned 64-bit values. It follows the register state in the same cycle that the state changes.
- R8: After reset the counter is zero, every compare register is all ones and every `irq` bit is low.
- R9: Some addresses are unmapped. These are addresses with bits 1:0 not zero, offsets 0x8/0xC of the hart-less window, and windows above it. Reads from them return zero, and writes to them change no register.
- R10: Rewriting a compare register above the current count drops that hart's interrupt. Rewriting it at or below the count raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter increment enable for this cycle |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables for the write |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | NUM_HARTS | Timer interrupt per hart, level |

## Verification
A corrupted counter shows at once in the time words of every window, and the next tick edge shows it again. A misrouted write appears on the read path in the cycle after the write edge: a lost byte, an alias that accepted data, or a compare landing in the wrong hart. A wrong comparison, such as a signed compare or a broken carry between the halves, shows on `irq` in the first cycle where the count crosses the compare value. The bench therefore steps the counter across a 32-bit carry, across the sign bit and across its wrap point.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;

   localparam int unsigned DATA_W  = 32;
   localparam int unsigned BE_W    = DATA_W / 8;
   localparam int unsigned TIME_W  = 2 * DATA_W;
   localparam int unsigned WIN_LSB = 4;

   typedef enum logic [1:0] {
      SEL_NONE  = 2'd0,
      SEL_CMP   = 2'd1,
      SEL_ALIAS = 2'd2,
      SEL_PHYS  = 2'd3
   } sel_kind_e;

   // byte-enable merge of new data into a current word
   function automatic logic [DATA_W-1:0] merge_bytes(
      input logic [DATA_W-1:0] cur,
      input logic [DATA_W-1:0] nw,
      input logic [BE_W-1:0]   be
   );
      logic [DATA_W-1:0] r;
      for (int b = 0; b < int'(BE_W); b++) begin
         r[b*8 +: 8] = be[b] ? nw[b*8 +: 8] : cur[b*8 +: 8];
      end
      return r;
   endfunction

endpackage

// File: rtl/gtmr_decode.sv
module gtmr_decode
   import gtmr_pkg::*;
#(
   parameter int unsigned NUM_HARTS = 4,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned HART_W    = 2
) (
   input  logic [ADDR_W-1:0] addr,
   output sel_kind_e         kind,
   output logic              upper,
   output logic [HART_W-1:0] hart
);

   localparam int unsigned     WIN_W    = ADDR_W - WIN_LSB;
   localparam logic [WIN_W-1:0] PHYS_WIN = WIN_W'(NUM_HARTS);

   logic [WIN_W-1:0] win;
   logic [1:0]       word;
   logic             aligned;

   assign win     = addr[ADDR_W-1:WIN_LSB];
   assign word    = addr[3:2];
   assign aligned = (addr[1:0] == 2'b00);

   always_comb begin
      kind = SEL_NONE;
      if (aligned) begin
         if (win < PHYS_WIN) begin
            kind = word[1] ? SEL_ALIAS : SEL_CMP;
         end else if ((win == PHYS_WIN) && !word[1]) begin
            kind = SEL_PHYS;
         end
      end
   end

   assign upper = word[0];
   assign hart  = HART_W'(win);

endmodule

// File: rtl/gtmr_counter.sv
module gtmr_counter
   import gtmr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [DATA_W-1:0] wdata,
   input  logic [BE_W-1:0]   be,
   output logic [TIME_W-1:0] time_q
);

   logic [DATA_W-1:0] lo_next;
   logic [DATA_W-1:0] hi_next;

   always_comb begin
      lo_next = time_q[DATA_W-1:0];
      hi_next = time_q[TIME_W-1:DATA_W];
      if (wr_lo) lo_next = merge_bytes(time_q[DATA_W-1:0], wdata, be);
      if (wr_hi) hi_next = merge_bytes(time_q[TIME_W-1:DATA_W], wdata, be);
   end

   // software write wins over the tick
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         time_q <= '0;
      end else if (wr_lo || wr_hi) begin
         time_q <= {hi_next, lo_next};
      end else if (tick) begin
         time_q <= time_q + TIME_W'(1);
      end
   end

endmodule

// File: rtl/gtmr_cmp_slot.sv
module gtmr_cmp_slot
   import gtmr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [DATA_W-1:0] wdata,
   input  logic [BE_W-1:0]   be,
   input  logic [TIME_W-1:0] time_now,
   output logic [TIME_W-1:0] cmp_q,
   output logic              irq
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_q <= '1;
      end else begin
         if (wr_lo) cmp_q[DATA_W-1:0]      <= merge_bytes(cmp_q[DATA_W-1:0], wdata, be);
         if (wr_hi) cmp_q[TIME_W-1:DATA_W] <= merge_bytes(cmp_q[TIME_W-1:DATA_W], wdata, be);
      end
   end

   // absolute, unsigned comparison
   assign irq = (time_now >= cmp_q);

endmodule

// File: rtl/grouped_timer.sv
module grouped_timer
   import gtmr_pkg::*;
#(
   parameter int unsigned NUM_HARTS = 4,
   parameter int unsigned ADDR_W    = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_en,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   input  logic [BE_W-1:0]      bus_be,
   output logic [DATA_W-1:0]    bus_rdata,
   output logic [NUM_HARTS-1:0] irq
);

   localparam int unsigned HART_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;
   localparam int unsigned NEED_W = $clog2((NUM_HARTS + 1) * (1 << WIN_LSB));

   if (NUM_HARTS < 1) begin : g_chk_harts
      $error("grouped_timer: NUM_HARTS must be at least 1");
   end
   if (ADDR_W < NEED_W) begin : g_chk_addr
      $error("grouped_timer: ADDR_W too small for the window map");
   end

   sel_kind_e         kind;
   logic              upper;
   logic [HART_W-1:0] hart;
   logic [TIME_W-1:0] time_q;
   logic [TIME_W-1:0] cmp_all [NUM_HARTS];
   logic              wr_phys;

   gtmr_decode #(
      .NUM_HARTS (NUM_HARTS),
      .ADDR_W    (ADDR_W),
      .HART_W    (HART_W)
   ) u_decode (
      .addr  (bus_addr),
      .kind  (kind),
      .upper (upper),
      .hart  (hart)
   );

   assign wr_phys = bus_wr && (kind == SEL_PHYS);

   gtmr_counter u_counter (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick_en),
      .wr_lo  (wr_phys && !upper),
      .wr_hi  (wr_phys && upper),
      .wdata  (bus_wdata),
      .be     (bus_be),
      .time_q (time_q)
   );

   for (genvar i = 0; i < int'(NUM_HARTS); i++) begin : g_hart
      logic sel_me;
      assign sel_me = bus_wr && (kind == SEL_CMP) && (hart == HART_W'(i));

      gtmr_cmp_slot u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_lo    (sel_me && !upper),
         .wr_hi    (sel_me && upper),
         .wdata    (bus_wdata),
         .be       (bus_be),
         .time_now (time_q),
         .cmp_q    (cmp_all[i]),
         .irq      (irq[i])
      );
   end

   // every time view reads the one physical counter
   always_comb begin
      unique case (kind)
         SEL_CMP:   bus_rdata = upper ? cmp_all[hart][TIME_W-1:DATA_W] : cmp_all[hart][DATA_W-1:0];
         SEL_ALIAS,
         SEL_PHYS:  bus_rdata = upper ? time_q[TIME_W-1:DATA_W] : time_q[DATA_W-1:0];
         default:   bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/gtmr_checker.sv
module gtmr_checker #(
   parameter int unsigned NUM_HARTS = 4,
   parameter int unsigned ADDR_W    = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 tick_en,
   input logic                 bus_wr,
   input logic [ADDR_W-1:0]    bus_addr,
   input logic [31:0]          bus_wdata,
   input logic [3:0]           bus_be,
   input logic [31:0]          bus_rdata,
   input logic [NUM_HARTS-1:0] irq,
   input logic [63:0]          time_q
);

   localparam int unsigned     WIN_W = ADDR_W - 4;
   localparam logic [WIN_W-1:0] TOP   = WIN_W'(NUM_HARTS);

   logic [WIN_W-1:0] win;
   logic             aligned;
   logic             alias_hit;
   logic             phys_hit;
   logic             unmapped;
   logic [31:0]      time_word;

   assign win       = bus_addr[ADDR_W-1:4];
   assign aligned   = (bus_addr[1:0] == 2'b00);
   assign alias_hit = aligned && (win < TOP) && bus_addr[3];
   assign phys_hit  = aligned && (win == TOP) && !bus_addr[3];
   assign unmapped  = !aligned || (win > TOP) || ((win == TOP) && bus_addr[3]);
   assign time_word = bus_addr[2] ? time_q[63:32] : time_q[31:0];

   assert_alias_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (alias_hit || phys_hit) |-> (bus_rdata == time_word));

   assert_alias_ro_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && alias_hit && !tick_en) |=> (time_q == $past(time_q)));

   assert_tick_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && !(bus_wr && phys_hit)) |=> (time_q == $past(time_q) + 64'd1));

   assert_write_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && phys_hit && !bus_addr[2] && (bus_be == 4'hF)) |=> (time_q[31:0] == $past(bus_wdata)));

   assert_reset_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (irq == '0));

   assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      unmapped |-> (bus_rdata == 32'd0));

   for (genvar i = 0; i < int'(NUM_HARTS); i++) begin : g_irq
      // with no bus write and no wrap, a raised interrupt stays raised
      assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(irq[i]) && !$past(bus_wr) && ($past(time_q) != 64'hFFFF_FFFF_FFFF_FFFF)) |-> irq[i]);
   end

endmodule

bind grouped_timer gtmr_checker #(
   .NUM_HARTS (NUM_HARTS),
   .ADDR_W    (ADDR_W)
) u_gtmr_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_en   (tick_en),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_be    (bus_be),
   .bus_rdata (bus_rdata),
   .irq       (irq),
   .time_q    (time_q)
);

// File: tb/test_grouped_timer.sv
module test_grouped_timer;

   localparam int unsigned NH = 4;
   localparam int unsigned AW = 8;
   localparam logic [7:0]  PHYS = 8'h40;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_en = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [3:0]    bus_be = '0;
   logic [31:0]   bus_rdata;
   logic [NH-1:0] irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   grouped_timer #(.NUM_HARTS(NH), .ADDR_W(AW)) i_grouped_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_be    (bus_be),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr32(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
      @(negedge clk);
      bus_wr = 1'b0; bus_be = '0;
   endtask

   task automatic rd32(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic rd64(input logic [7:0] a, output logic [63:0] d);
      logic [31:0] lo, hi;
      rd32(a, lo);
      rd32(a + 8'h4, hi);
      d = {hi, lo};
   endtask

   task automatic set_time(input logic [63:0] v);
      wr32(PHYS + 8'h4, v[63:32], 4'hF);
      wr32(PHYS, v[31:0], 4'hF);
   endtask

   task automatic set_cmp(input int h, input logic [63:0] v);
      wr32(8'(h * 16) + 8'h4, v[63:32], 4'hF);
      wr32(8'(h * 16), v[31:0], 4'hF);
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   task automatic t_reset;
      logic [63:0] v;
      rd64(PHYS, v);
      chk("R8 counter reset", v, 64'd0);
      for (int h = 0; h < int'(NH); h++) begin
         rd64(8'(h * 16), v);
         chk("R8 compare reset", v, '1);
      end
      chk("R8 irq reset", 64'(irq), 64'd0);
   endtask

   task automatic t_alias_views;
      logic [63:0] v;
      set_time(64'h0123_4567_89AB_CDEF);
      rd64(PHYS, v);
      chk("R3 physical write", v, 64'h0123_4567_89AB_CDEF);
      for (int h = 0; h < int'(NH); h++) begin
         rd64(8'(h * 16) + 8'h8, v);
         chk("R1 alias view", v, 64'h0123_4567_89AB_CDEF);
      end
   endtask

   task automatic t_alias_readonly;
      logic [63:0] v;
      wr32(8'h18, 32'hDEAD_BEEF, 4'hF);
      wr32(8'h3C, 32'h1111_2222, 4'hF);
      rd64(PHYS, v);
      chk("R2 alias write ignored", v, 64'h0123_4567_89AB_CDEF);
   endtask

   task automatic t_strobes;
      logic [63:0] v;
      set_time(64'h5555_6666_1122_3344);
      wr32(PHYS, 32'hAABB_CCDD, 4'b0101);
      rd64(PHYS, v);
      chk("R3 byte strobes low half", v, 64'h5555_6666_11BB_33DD);
      wr32(PHYS + 8'h4, 32'h0000_0077, 4'b0001);
      rd64(PHYS, v);
      chk("R3 high half only", v, 64'h5555_6677_11BB_33DD);
   endtask

   task automatic t_tick_and_priority;
      logic [63:0] v;
      set_time(64'd10);
      ticks(5);
      rd64(PHYS, v);
      chk("R4 tick count", v, 64'd15);
      @(negedge clk);
      tick_en = 1'b1; bus_wr = 1'b1; bus_addr = PHYS; bus_wdata = 32'h1234; bus_be = 4'hF;
      @(negedge clk);
      tick_en = 1'b0; bus_wr = 1'b0; bus_be = '0;
      rd64(PHYS, v);
      chk("R5 write beats tick", v, 64'h1234);
      set_time('1);
      ticks(1);
      rd64(PHYS, v);
      chk("R4 wrap to zero", v, 64'd0);
   endtask

   task automatic t_cmp_separate;
      logic [63:0] v;
      set_cmp(2, 64'h0000_0009_0000_0007);
      rd64(8'h20, v);
      chk("R6 compare stored", v, 64'h0000_0009_0000_0007);
      rd64(8'h10, v);
      chk("R6 neighbour untouched", v, '1);
      rd64(8'h30, v);
      chk("R6 neighbour untouched", v, '1);
      set_cmp(2, '1);
   endtask

   task automatic t_irq;
      set_time(64'd99);
      set_cmp(1, 64'd100);
      chk("R7 below compare", 64'(irq), 64'd0);
      ticks(1);
      chk("R7 reached compare", 64'(irq), 64'b0010);
      set_cmp(1, 64'd101);
      chk("R10 raise compare clears", 64'(irq), 64'd0);
      set_cmp(3, 64'd50);
      chk("R10 lower compare sets", 64'(irq), 64'b1000);
      set_cmp(3, '1);
      set_cmp(1, '1);
      set_cmp(0, 64'h0000_0001_0000_0000);
      set_time(64'h0000_0000_FFFF_FFFF);
      chk("R7 carry pending", 64'(irq[0]), 64'd0);
      ticks(1);
      chk("R7 carry reached", 64'(irq[0]), 64'd1);
      set_cmp(2, 64'h8000_0000_0000_0000);
      set_time(64'h7FFF_FFFF_FFFF_FFFF);
      chk("R7 unsigned below", 64'(irq[2]), 64'd0);
      wr32(PHYS + 8'h4, 32'h8000_0000, 4'hF);
      wr32(PHYS, 32'h0, 4'hF);
      chk("R7 unsigned reached", 64'(irq[2]), 64'd1);
   endtask

   task automatic t_unmapped;
      logic [63:0] v;
      logic [31:0] w;
      set_time(64'h0000_00AA_0000_00BB);
      wr32(PHYS + 8'h8, 32'hFFFF_FFFF, 4'hF);
      wr32(PHYS + 8'h1, 32'hFFFF_FFFF, 4'hF);
      wr32(8'h50, 32'hFFFF_FFFF, 4'hF);
      wr32(8'h01, 32'h0, 4'hF);
      rd64(PHYS, v);
      chk("R9 writes ignored", v, 64'h0000_00AA_0000_00BB);
      rd64(8'h00, v);
      chk("R9 misaligned compare write ignored", v, 64'h0000_0001_0000_0000);
      rd32(PHYS + 8'h8, w);
      chk("R9 hole reads zero", 64'(w), 64'd0);
      rd32(8'hF0, w);
      chk("R9 beyond map reads zero", 64'(w), 64'd0);
      rd32(PHYS + 8'h2, w);
      chk("R9 misaligned reads zero", 64'(w), 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_alias_views();
      t_alias_readonly();
      t_strobes();
      t_tick_and_priority();
      t_cmp_separate();
      t_irq();
      t_unmapped();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

endmodule